// File: doc/BRIEF.md
# Thread-Group Dispatcher

This block hands out the thread groups of one kernel to a row of compute cores. A launch pulse latches the kernel shape: how many groups there are, plus per-group demand for warps, registers and shared memory. It also latches each core's capacity in the same three resources. From these values the block works out how many groups one core may hold at once. That figure is the smallest of the three whole-number quotients of capacity over demand.

Dispatch runs in two phases. In the fill phase, groups leave in ascending order, one per cycle, dealt to core 0, 1, 2 and so on in turn. This continues until every core is at its limit or the groups run out. After that the block only reacts to completion pulses from the cores. A core that reports a finished group has a free slot, and that slot receives the next group. Each dispatch appears as a one-cycle event that carries the group number and the core number. A done flag rises once all groups have been handed out and all of them have finished.

Top module: `tg_dispatcher`

## Requirements
- R1: After reset, `dispValid`, `kernelDone` and `limitErr` are all low.
- R2: The per-core limit is the minimum of floor(coreWarpCap/warpsPerGroup), floor(coreRegCap/regsPerGroup) and floor(coreSmemCap/smemPerGroup). A demand of zero places no constraint, and the result saturates at 2^OCC_W-1. With no completions, exactly min(NUM_CORES*limit, totalGroups) groups are dispatched.
- R3: Groups are dispatched with IDs 0, 1, 2, ... in order. In the fill phase they go out on consecutive cycles to cores 0, 1, ..., NUM_CORES-1, 0, 1, ... in turn.
- R4: No core ever holds more resident groups than the limit.
- R5: After the fill phase, a group is dispatched only to a core that has a free slot. A completion pulse sampled at clock edge k frees the slot, and the dispatch to that core is visible after edge k+1.
- R6: When several cores have free slots, the lowest-numbered core is served first, with one dispatch per cycle.
- R7: A limit of zero sets `limitErr`, which stays set until the next accepted `start`. No group is dispatched, and `kernelDone` stays low.
- R8: `kernelDone` rises only once every group has been dispatched and every one has been reported complete. A kernel of zero groups completes with no dispatch. `kernelDone` and `dispValid` are never high together.
- R9: A `start` pulse while a kernel is in progress is ignored. The dispatch stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse; configuration is latched when accepted |
| totalGroups | input | GRP_W | Number of groups in the kernel |
| warpsPerGroup | input | CAP_W | Warps each group needs |
| regsPerGroup | input | CAP_W | Registers each group needs |
| smemPerGroup | input | CAP_W | Shared memory each group needs |
| coreWarpCap | input | CAP_W | Hardware warp slots per core |
| coreRegCap | input | CAP_W | Register file size per core |
| coreSmemCap | input | CAP_W | Shared memory size per core |
| groupDone | input | NUM_CORES | One bit per core: a resident group finished this cycle |
| dispValid | output | 1 | Dispatch event this cycle |
| dispGroup | output | GRP_W | Group ID of the dispatch |
| dispCore | output | CORE_W | Target core of the dispatch |
| kernelDone | output | 1 | All groups dispatched and completed |
| limitErr | output | 1 | Computed per-core limit was zero |

## Verification
The bench uses the default parameters: three cores, ten-bit group IDs, six-bit occupancy and sixteen-bit capacities. With these values, the twelve-group, two-per-core example can be replayed exactly. A fully unconstrained kernel reaches the saturated limit of 63, and a 49-warp group against 48 warp slots gives a zero limit. Randomly shaped kernels then cover limits from a few groups up to dozens, with completions arriving in arbitrary patterns across the three cores.

// File: rtl/tg_disp_pkg.sv
package tg_disp_pkg;
  localparam int CORE_IDX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_DONE,
    ST_ERR
  } dispState_e;

  typedef struct packed {
    logic                  load;
    logic                  issue;
    logic [CORE_IDX_W-1:0] core;
  } dispStrobe_t;
endpackage

// File: rtl/tg_disp_dp.sv
module tg_disp_dp
  import tg_disp_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int GRP_W     = 10,
  parameter int OCC_W     = 6,
  parameter int CAP_W     = 16,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dispStrobe_t          strobe,
  input  logic [GRP_W-1:0]     totalGroups,
  input  logic [CAP_W-1:0]     warpsPerGroup,
  input  logic [CAP_W-1:0]     regsPerGroup,
  input  logic [CAP_W-1:0]     smemPerGroup,
  input  logic [CAP_W-1:0]     coreWarpCap,
  input  logic [CAP_W-1:0]     coreRegCap,
  input  logic [CAP_W-1:0]     coreSmemCap,
  input  logic [NUM_CORES-1:0] groupDone,
  output logic [OCC_W-1:0]     limit,
  output logic [NUM_CORES-1:0] freeMask,
  output logic                 allIdle,
  output logic                 groupsLeft,
  output logic                 dispValid,
  output logic [GRP_W-1:0]     dispGroup,
  output logic [CORE_W-1:0]    dispCore
);
  localparam logic [CAP_W-1:0] OCC_MAX = CAP_W'((1 << OCC_W) - 1);

  // Whole-number slots for one resource; zero demand means unconstrained.
  function automatic logic [OCC_W-1:0] slotsFor(input logic [CAP_W-1:0] cap,
                                                input logic [CAP_W-1:0] dem);
    logic [CAP_W-1:0] q;
    if (dem == '0) return OCC_W'(OCC_MAX);
    q = cap / dem;
    return (q > OCC_MAX) ? OCC_W'(OCC_MAX) : q[OCC_W-1:0];
  endfunction

  logic [OCC_W-1:0] qWarp, qReg, qSmem, limitNew;
  logic [OCC_W-1:0] limitQ;
  logic [GRP_W-1:0] totalQ, nextGrp;
  logic [OCC_W-1:0] occ [NUM_CORES];
  logic [NUM_CORES-1:0] busyMask;

  always_comb begin
    qWarp    = slotsFor(coreWarpCap, warpsPerGroup);
    qReg     = slotsFor(coreRegCap,  regsPerGroup);
    qSmem    = slotsFor(coreSmemCap, smemPerGroup);
    limitNew = qWarp;
    if (qReg  < limitNew) limitNew = qReg;
    if (qSmem < limitNew) limitNew = qSmem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitQ    <= '0;
      totalQ    <= '0;
      nextGrp   <= '0;
      dispValid <= 1'b0;
      dispGroup <= '0;
      dispCore  <= '0;
    end else begin
      dispValid <= strobe.issue;
      if (strobe.load) begin
        limitQ  <= limitNew;
        totalQ  <= totalGroups;
        nextGrp <= '0;
      end else if (strobe.issue) begin
        nextGrp   <= nextGrp + GRP_W'(1);
        dispGroup <= nextGrp;
        dispCore  <= strobe.core[CORE_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic inc, dec;
    assign inc = strobe.issue && (strobe.core == CORE_IDX_W'(i));
    assign dec = groupDone[i] && (occ[i] != '0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            occ[i] <= '0;
      else if (strobe.load) occ[i] <= '0;
      else                  occ[i] <= occ[i] + OCC_W'(inc) - OCC_W'(dec);
    end
    assign freeMask[i] = occ[i] < limitQ;
    assign busyMask[i] = occ[i] != '0;
  end

  assign limit      = limitQ;
  assign allIdle    = ~|busyMask;
  assign groupsLeft = nextGrp != totalQ;
endmodule

// File: rtl/tg_disp_ctrl.sv
module tg_disp_ctrl
  import tg_disp_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int OCC_W     = 6,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [OCC_W-1:0]     limit,
  input  logic [NUM_CORES-1:0] freeMask,
  input  logic                 allIdle,
  input  logic                 groupsLeft,
  output dispStrobe_t          strobe,
  output logic                 kernelDone,
  output logic                 limitErr
);
  localparam int FILL_W = OCC_W + $clog2(NUM_CORES + 1);

  dispState_e        state;
  logic [CORE_W-1:0] rrPtr, lowIdx;
  logic [FILL_W-1:0] fillCnt, fillTarget;
  logic              lowFound;

  assign fillTarget = FILL_W'(limit) * FILL_W'(NUM_CORES);

  always_comb begin
    lowFound = 1'b0;
    lowIdx   = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (freeMask[i]) begin
        lowFound = 1'b1;
        lowIdx   = CORE_W'(i);
      end
    end
  end

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERR: strobe.load = start;
      ST_FILL: begin
        if (limit != '0 && fillCnt != fillTarget && groupsLeft) begin
          strobe.issue = 1'b1;
          strobe.core  = CORE_IDX_W'(rrPtr);
        end
      end
      ST_DRAIN: begin
        if (groupsLeft && lowFound) begin
          strobe.issue = 1'b1;
          strobe.core  = CORE_IDX_W'(lowIdx);
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rrPtr   <= '0;
      fillCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start) begin
            state   <= ST_FILL;
            rrPtr   <= '0;
            fillCnt <= '0;
          end
        end
        ST_FILL: begin
          if (limit == '0) state <= ST_ERR;
          else if (strobe.issue) begin
            rrPtr   <= (rrPtr == CORE_W'(NUM_CORES - 1)) ? '0 : rrPtr + CORE_W'(1);
            fillCnt <= fillCnt + FILL_W'(1);
          end else state <= ST_DRAIN;
        end
        ST_DRAIN: if (!groupsLeft && allIdle) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign kernelDone = state == ST_DONE;
  assign limitErr   = state == ST_ERR;
endmodule

// File: rtl/tg_dispatcher.sv
module tg_dispatcher
  import tg_disp_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int GRP_W     = 10,
  parameter int OCC_W     = 6,
  parameter int CAP_W     = 16,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [GRP_W-1:0]     totalGroups,
  input  logic [CAP_W-1:0]     warpsPerGroup,
  input  logic [CAP_W-1:0]     regsPerGroup,
  input  logic [CAP_W-1:0]     smemPerGroup,
  input  logic [CAP_W-1:0]     coreWarpCap,
  input  logic [CAP_W-1:0]     coreRegCap,
  input  logic [CAP_W-1:0]     coreSmemCap,
  input  logic [NUM_CORES-1:0] groupDone,
  output logic                 dispValid,
  output logic [GRP_W-1:0]     dispGroup,
  output logic [CORE_W-1:0]    dispCore,
  output logic                 kernelDone,
  output logic                 limitErr
);
  dispStrobe_t          strobe;
  logic [OCC_W-1:0]     limit;
  logic [NUM_CORES-1:0] freeMask;
  logic                 allIdle, groupsLeft;

  tg_disp_ctrl #(.NUM_CORES(NUM_CORES), .OCC_W(OCC_W), .CORE_W(CORE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .limit(limit), .freeMask(freeMask),
    .allIdle(allIdle), .groupsLeft(groupsLeft), .strobe(strobe),
    .kernelDone(kernelDone), .limitErr(limitErr)
  );

  tg_disp_dp #(.NUM_CORES(NUM_CORES), .GRP_W(GRP_W), .OCC_W(OCC_W), .CAP_W(CAP_W),
               .CORE_W(CORE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .totalGroups(totalGroups),
    .warpsPerGroup(warpsPerGroup), .regsPerGroup(regsPerGroup), .smemPerGroup(smemPerGroup),
    .coreWarpCap(coreWarpCap), .coreRegCap(coreRegCap), .coreSmemCap(coreSmemCap),
    .groupDone(groupDone), .limit(limit), .freeMask(freeMask), .allIdle(allIdle),
    .groupsLeft(groupsLeft), .dispValid(dispValid), .dispGroup(dispGroup), .dispCore(dispCore)
  );
endmodule

// File: rtl/tg_dispatcher_chk.sv
module tg_dispatcher_chk #(
  parameter int NUM_CORES = 3,
  parameter int GRP_W     = 10,
  parameter int CORE_W    = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              dispValid,
  input logic [GRP_W-1:0]  dispGroup,
  input logic [CORE_W-1:0] dispCore,
  input logic              kernelDone,
  input logic              limitErr
);
  logic             busy;
  logic [GRP_W-1:0] expGrp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      expGrp <= '0;
    end else if (start && (!busy || kernelDone || limitErr)) begin
      busy   <= 1'b1;
      expGrp <= '0;
    end else begin
      if (kernelDone || limitErr) busy <= 1'b0;
      if (dispValid) expGrp <= expGrp + GRP_W'(1);
    end
  end

  // R3
  grp_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> dispGroup == expGrp);

  // R5
  core_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> dispCore < CORE_W'(NUM_CORES));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    limitErr |-> !dispValid);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    limitErr && !start |=> limitErr);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    kernelDone |-> !dispValid);
endmodule

bind tg_dispatcher tg_dispatcher_chk #(.NUM_CORES(NUM_CORES), .GRP_W(GRP_W), .CORE_W(CORE_W))
  chk_i (.clk(clk), .rstN(rstN), .start(start), .dispValid(dispValid), .dispGroup(dispGroup),
         .dispCore(dispCore), .kernelDone(kernelDone), .limitErr(limitErr));

// File: tb/tg_dispatcher_tb.sv
`timescale 1ns/1ps
module tg_dispatcher_tb_top;
  localparam int NC = 3;
  localparam int GW = 10;
  localparam int CW = 16;
  localparam int OMAX = 63;

  logic clk = 0, rstN = 0, start = 0;
  logic [GW-1:0] totalGroups = '0;
  logic [CW-1:0] warpsPerGroup = '0, regsPerGroup = '0, smemPerGroup = '0;
  logic [CW-1:0] coreWarpCap = '0, coreRegCap = '0, coreSmemCap = '0;
  logic [NC-1:0] groupDone = '0;
  logic dispValid, kernelDone, limitErr;
  logic [GW-1:0] dispGroup;
  logic [1:0] dispCore;

  tg_dispatcher dut_i (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;
  int recN = 0, expGrp = 0, expLim = 0;
  int recG [512];
  int recC [512];
  int recT [512];
  int occB [NC];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slotsB(input int cap, input int dem);
    int q;
    if (dem == 0) return OMAX;
    q = cap / dem;
    return (q > OMAX) ? OMAX : q;
  endfunction

  function automatic int limB(input int w, input int wc, input int r, input int rc,
                              input int s, input int sc);
    int m;
    m = slotsB(wc, w);
    if (slotsB(rc, r) < m) m = slotsB(rc, r);
    if (slotsB(sc, s) < m) m = slotsB(sc, s);
    return m;
  endfunction

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finishRun();
    end
  end

  // Monitor: records dispatches, checks order (R3) and occupancy bound (R4)
  always @(negedge clk) begin
    if (rstN && dispValid) begin
      chk(int'(dispGroup) == expGrp, "R3 group order", int'(dispGroup), expGrp);
      chk(occB[dispCore] < expLim, "R4 core occupancy", occB[dispCore] + 1, expLim);
      occB[dispCore] = occB[dispCore] + 1;
      expGrp++;
      if (recN < 512) begin
        recG[recN] = int'(dispGroup);
        recC[recN] = int'(dispCore);
        recT[recN] = cyc;
      end
      recN++;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart(input int tot, input int w, input int wc, input int r,
                            input int rc, input int s, input int sc, input bit fresh);
    @(negedge clk);
    #2;
    totalGroups = GW'(tot); warpsPerGroup = CW'(w); coreWarpCap = CW'(wc);
    regsPerGroup = CW'(r); coreRegCap = CW'(rc); smemPerGroup = CW'(s); coreSmemCap = CW'(sc);
    if (fresh) begin
      recN = 0; expGrp = 0; expLim = limB(w, wc, r, rc, s, sc);
      for (int i = 0; i < NC; i++) occB[i] = 0;
    end
    start = 1;
    @(negedge clk);
    #2;
    start = 0;
  endtask

  // Drives one completion mask for one cycle; returns the cycle count at drive time
  task automatic pulseDone(input logic [NC-1:0] mask, output int when);
    @(negedge clk);
    #2;
    when = cyc;
    groupDone = mask;
    for (int i = 0; i < NC; i++) if (mask[i]) occB[i] = occB[i] - 1;
    @(negedge clk);
    #2;
    groupDone = '0;
  endtask

  function automatic logic [NC-1:0] occMask();
    logic [NC-1:0] m;
    for (int i = 0; i < NC; i++) m[i] = occB[i] > 0;
    return m;
  endfunction

  task automatic drainAll(input int tot, input bit randomMask, input string req);
    int t;
    for (int it = 0; it < 4000 && !kernelDone; it++) begin
      if (randomMask) pulseDone(NC'($urandom) & occMask(), t);
      else begin
        pulseDone(occMask(), t);
        waitCyc(2);
      end
    end
    waitCyc(3);
    chk(recN == tot, req, recN, tot);
    chk(kernelDone == 1'b1, req, int'(kernelDone), 1);
  endtask

  task automatic checkFill(input int n, input string req);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      if (recC[i] != i % NC) ok = 0;
      if (i > 0 && recT[i] != recT[i-1] + 1) ok = 0;
    end
    chk(ok, req, ok, 1);
  endtask

  initial begin
    int t, fillN, tot, w, r, s;
    void'($urandom(32'd1234));
    for (int i = 0; i < NC; i++) occB[i] = 0;
    waitCyc(3);
    #2 rstN = 1;
    waitCyc(1);
    // R1 reset state
    chk(dispValid == 0, "R1 dispValid", int'(dispValid), 0);
    chk(kernelDone == 0, "R1 kernelDone", int'(kernelDone), 0);
    chk(limitErr == 0, "R1 limitErr", int'(limitErr), 0);

    // Directed: 12 groups, 3 cores, limit 2 (warps 48/24, regs 8000/1000, smem free)
    pulseStart(12, 24, 48, 1000, 8000, 0, 49152, 1);
    waitCyc(12);
    chk(recN == 6, "R2 fill count limit 2", recN, 6);
    checkFill(6, "R3 fill round robin");
    chk(kernelDone == 0, "R8 not done while groups remain", int'(kernelDone), 0);
    // R9: start during the run is ignored
    pulseStart(3, 1, 48, 0, 1, 0, 1, 0);
    waitCyc(6);
    chk(recN == 6, "R9 start ignored", recN, 6);
    // R5: core 2 completes -> group 6 to core 2 two cycles later
    pulseDone(3'b100, t);
    waitCyc(3);
    chk(recN == 7 && recG[6] == 6 && recC[6] == 2, "R5 refill core", recC[6], 2);
    chk(recT[6] - t == 2, "R5 refill latency", recT[6] - t, 2);
    // R6: cores 0 and 1 complete together -> core 0 first, then core 1
    pulseDone(3'b011, t);
    waitCyc(4);
    chk(recN == 9 && recC[7] == 0 && recC[8] == 1, "R6 lowest core first", recC[7], 0);
    chk(recT[7] - t == 2 && recT[8] - t == 3, "R6 one per cycle", recT[8] - t, 3);
    drainAll(12, 0, "R8 kernel done after all complete");

    // R7: 49 warps against 48 slots -> limit zero
    pulseStart(5, 49, 48, 0, 1, 0, 1, 1);
    waitCyc(6);
    chk(limitErr == 1, "R7 limitErr set", int'(limitErr), 1);
    chk(recN == 0, "R7 nothing dispatched", recN, 0);
    chk(kernelDone == 0, "R7 no kernelDone", int'(kernelDone), 0);

    // R8: empty kernel
    pulseStart(0, 4, 48, 0, 1, 0, 1, 1);
    waitCyc(5);
    chk(kernelDone == 1 && limitErr == 0, "R8 empty kernel done", int'(kernelDone), 1);
    chk(recN == 0, "R8 empty kernel no dispatch", recN, 0);

    // R2: all demands zero -> saturated limit 63; 100 groups all go in the fill
    pulseStart(100, 0, 48, 0, 1, 0, 1, 1);
    waitCyc(110);
    chk(recN == 100, "R2 saturated limit fill", recN, 100);
    checkFill(100, "R3 saturated round robin");
    drainAll(100, 0, "R8 saturated kernel done");

    // Random kernels
    for (int k = 0; k < 6; k++) begin
      w = 1 + int'($urandom % 16);
      r = 256 + int'($urandom % 4000);
      s = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 12000);
      tot = 5 + int'($urandom % 80);
      pulseStart(tot, w, 48, r, 32768, s, 49152, 1);
      fillN = minI(NC * expLim, tot);
      waitCyc(tot + 8);
      chk(recN == fillN, "R2 random fill count", recN, fillN);
      checkFill(fillN, "R3 random fill order");
      drainAll(tot, 1, "R8 random kernel done");
    end

    finishRun();
  end
endmodule